// File: doc/BRIEF.md
# Message Buffer Ring Pointers with Half and Wrap Interrupts

This block keeps the write addresses for two ring buffers that share one RAM: a descriptor ring, which takes a fixed-length entry for every stored message, and a payload ring, which takes a variable number of words per message (for a receive transfer, the data words followed by the responder's status word). Each ring has its own size select, and a pointer wraps inside its selected size while the address bits above that size stay put. This lets the host place each ring anywhere in memory by preloading the pointer.

A message is offered with `msg_valid` and a payload word count while `msg_ready` is high. A small sequencer then walks four named states. ST_IDLE accepts the message (transition ACCEPT) and moves to ST_CMD. ST_CMD advances the descriptor pointer by the entry length (transition CMD_DONE) and moves to ST_DATA. ST_DATA advances the payload pointer by the word count (transition DATA_DONE) and moves to ST_EOM. ST_EOM raises the end-of-message pulse (transition RETIRE) and returns to ST_IDLE. Each ring raises a one-cycle pulse when an advance carries its offset from below the half-way mark to or past it, and another when the advance wraps past the end. The host can then drain one half while the other half fills. Every pulse has its own enable bit.

Top module: `msg_ring_ptrs`

## Requirements
- R1: After reset both pointers are zero, all five interrupt outputs are low and `msg_ready` is high.
- R2: A message accepted in ST_IDLE drops `msg_ready` after the next edge, and the descriptor pointer has advanced by DESC_WORDS (default 4) after the second edge.
- R3: The payload pointer has advanced by `msg_words` one edge after the descriptor pointer advanced, and never moves in any other cycle unless preloaded.
- R4: `irq_eom` is high for one cycle one edge after the payload advance, when `irq_en[0]` is set, and `msg_ready` is high again in that same cycle.
- R5: The descriptor ring size is 256 << (2*`cmd_size_sel`) words (256, 1024, 4096 or 16384), and its offset wraps modulo that size.
- R6: The payload ring size is 512 << `data_size_sel` words (512 up to 65536), and its offset wraps modulo that size.
- R7: Pointer bits at and above log2 of the selected size never change on an advance.
- R8: A half pulse (`irq_cmd_half` enabled by `irq_en[1]`, `irq_data_half` enabled by `irq_en[3]`) fires when an advance takes the offset from below size/2 to size/2 or above, counting the advance as if unwrapped.
- R9: A wrap pulse (`irq_cmd_wrap` enabled by `irq_en[2]`, `irq_data_wrap` enabled by `irq_en[4]`) fires when offset plus step reaches the size. An advance that does both fires both pulses in the same cycle.
- R10: Every interrupt output is a single-cycle pulse, and a cleared enable bit keeps its output low.
- R11: A preload sets the pointer to the load value after the next edge. It wins over an advance in the same cycle and suppresses that ring's rollover pulses for that cycle.
- R12: `msg_valid` is ignored while `msg_ready` is low; no extra advance follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_size_sel | input | 2 | Descriptor ring size select |
| data_size_sel | input | 3 | Payload ring size select |
| irq_en | input | 5 | Enables: [0] end of message, [1] desc half, [2] desc wrap, [3] payload half, [4] payload wrap |
| cmd_load | input | 1 | Preload strobe for descriptor pointer |
| cmd_load_ptr | input | 14 | Descriptor preload value |
| data_load | input | 1 | Preload strobe for payload pointer |
| data_load_ptr | input | 16 | Payload preload value |
| msg_valid | input | 1 | Message offered |
| msg_words | input | 9 | Payload words for the message |
| msg_ready | output | 1 | Sequencer idle, message can be taken |
| cmd_ptr | output | 14 | Descriptor write address |
| data_ptr | output | 16 | Payload write address |
| irq_eom | output | 1 | End-of-message pulse |
| irq_cmd_half | output | 1 | Descriptor half-way pulse |
| irq_cmd_wrap | output | 1 | Descriptor wrap pulse |
| irq_data_half | output | 1 | Payload half-way pulse |
| irq_data_wrap | output | 1 | Payload wrap pulse |

## Verification
The assertions assume that a step is always smaller than the selected ring size, so one advance can wrap at most once and cross the half mark at most once. They also assume that size selects only change while the sequencer is idle. The bench keeps `msg_words` below 512, the smallest payload ring, and the descriptor step is a fixed 4. It changes size selects only across a reset or while idle, and it drives preloads either in ST_IDLE or, for the priority case, held steady across a whole message.

// File: rtl/msg_ring_pkg.sv
package msg_ring_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_DATA = 2'd2,
        ST_EOM  = 2'd3
    } seq_state_e;

    localparam int IRQ_EOM_BIT       = 0;
    localparam int IRQ_CMD_HALF_BIT  = 1;
    localparam int IRQ_CMD_WRAP_BIT  = 2;
    localparam int IRQ_DATA_HALF_BIT = 3;
    localparam int IRQ_DATA_WRAP_BIT = 4;
    localparam int IRQ_COUNT         = 5;
endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
    parameter int AW      = 16,
    parameter int SELW    = 3,
    parameter int MIN_LG  = 9,
    parameter int STEP_LG = 1,
    parameter int NW      = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SELW-1:0] size_sel,
    input  logic            load,
    input  logic [AW-1:0]   load_val,
    input  logic            adv,
    input  logic [NW-1:0]   step,
    input  logic            en_half,
    input  logic            en_wrap,
    output logic [AW-1:0]   ptr,
    output logic            irq_half,
    output logic            irq_wrap
);
    localparam int XW = AW + 2;

    int            lg;
    logic [XW-1:0] size;
    logic [XW-1:0] half;
    logic [XW-1:0] mask;
    logic [XW-1:0] off;
    logic [XW-1:0] sum;
    logic [XW-1:0] nxt;
    logic          wrap_hit;
    logic          half_hit;

    always_comb begin
        lg       = MIN_LG + STEP_LG * int'(size_sel);
        size     = XW'(1) << lg;
        half     = size >> 1;
        mask     = size - XW'(1);
        off      = {2'b00, ptr} & mask;
        sum      = off + XW'(step);
        wrap_hit = (sum >= size);
        half_hit = ((off < half) && (sum >= half)) || (sum >= (size + half));
        nxt      = ({2'b00, ptr} & ~mask) | (sum & mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= '0;
            irq_half <= 1'b0;
            irq_wrap <= 1'b0;
        end else if (load) begin
            ptr      <= load_val;
            irq_half <= 1'b0;
            irq_wrap <= 1'b0;
        end else if (adv) begin
            ptr      <= nxt[AW-1:0];
            irq_half <= half_hit & en_half;
            irq_wrap <= wrap_hit & en_wrap;
        end else begin
            irq_half <= 1'b0;
            irq_wrap <= 1'b0;
        end
    end

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ptr == $past(load_val)) && !irq_half && !irq_wrap); // R11

    AST_HOLD_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(ptr)); // R3

    AST_HIGH_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> (({2'b00, ptr} & ~$past(mask)) == ({2'b00, $past(ptr)} & ~$past(mask)))); // R7

    AST_WRAP_LANDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        irq_wrap |-> (({2'b00, ptr} & $past(mask)) < XW'($past(step)))); // R9
endmodule

// File: rtl/msg_ring_ptrs.sv
module msg_ring_ptrs
    import msg_ring_pkg::*;
#(
    parameter int CMD_AW     = 14,
    parameter int DATA_AW    = 16,
    parameter int WORDS_W    = 9,
    parameter int DESC_WORDS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cmd_size_sel,
    input  logic [2:0]         data_size_sel,
    input  logic [4:0]         irq_en,
    input  logic               cmd_load,
    input  logic [CMD_AW-1:0]  cmd_load_ptr,
    input  logic               data_load,
    input  logic [DATA_AW-1:0] data_load_ptr,
    input  logic               msg_valid,
    input  logic [WORDS_W-1:0] msg_words,
    output logic               msg_ready,
    output logic [CMD_AW-1:0]  cmd_ptr,
    output logic [DATA_AW-1:0] data_ptr,
    output logic               irq_eom,
    output logic               irq_cmd_half,
    output logic               irq_cmd_wrap,
    output logic               irq_data_half,
    output logic               irq_data_wrap
);
    localparam logic [WORDS_W-1:0] DESC_STEP = WORDS_W'(DESC_WORDS);

    seq_state_e         state_q;
    seq_state_e         state_d;
    logic [WORDS_W-1:0] words_q;
    logic               cmd_adv;
    logic               data_adv;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (msg_valid) state_d = ST_CMD;
            ST_CMD:  state_d = ST_DATA;
            ST_DATA: state_d = ST_EOM;
            ST_EOM:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            words_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && msg_valid) words_q <= msg_words;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_eom <= 1'b0;
        else        irq_eom <= (state_q == ST_EOM) && irq_en[IRQ_EOM_BIT];
    end

    assign msg_ready = (state_q == ST_IDLE);
    assign cmd_adv   = (state_q == ST_CMD);
    assign data_adv  = (state_q == ST_DATA);

    ring_ptr #(
        .AW(CMD_AW), .SELW(2), .MIN_LG(8), .STEP_LG(2), .NW(WORDS_W)
    ) u_cmd_ring (
        .clk(clk), .rst_n(rst_n), .size_sel(cmd_size_sel),
        .load(cmd_load), .load_val(cmd_load_ptr),
        .adv(cmd_adv), .step(DESC_STEP),
        .en_half(irq_en[IRQ_CMD_HALF_BIT]), .en_wrap(irq_en[IRQ_CMD_WRAP_BIT]),
        .ptr(cmd_ptr), .irq_half(irq_cmd_half), .irq_wrap(irq_cmd_wrap)
    );

    ring_ptr #(
        .AW(DATA_AW), .SELW(3), .MIN_LG(9), .STEP_LG(1), .NW(WORDS_W)
    ) u_data_ring (
        .clk(clk), .rst_n(rst_n), .size_sel(data_size_sel),
        .load(data_load), .load_val(data_load_ptr),
        .adv(data_adv), .step(words_q),
        .en_half(irq_en[IRQ_DATA_HALF_BIT]), .en_wrap(irq_en[IRQ_DATA_WRAP_BIT]),
        .ptr(data_ptr), .irq_half(irq_data_half), .irq_wrap(irq_data_wrap)
    );

    AST_ACCEPT_GOES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_ready && msg_valid) |=> (state_q == ST_CMD)); // R2

    AST_BUSY_IGNORES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_ready |=> (state_q != ST_CMD)); // R12

    AST_EOM_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        irq_eom |-> ($past(state_q) == ST_EOM) && msg_ready); // R4

    AST_EOM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_eom |=> !irq_eom); // R10

    AST_CMD_WRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cmd_wrap |=> !irq_cmd_wrap); // R10

    AST_DATA_HALF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_data_half |=> !irq_data_half); // R10

    AST_CMD_IRQ_WHEN_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_cmd_half || irq_cmd_wrap) |-> ($past(state_q) == ST_CMD)); // R8

    AST_DATA_IRQ_WHEN_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_data_half || irq_data_wrap) |-> ($past(state_q) == ST_DATA)); // R9
endmodule

// File: tb/msg_ring_ptrs_tb.sv
module msg_ring_ptrs_tb;
    localparam int DESC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cmd_size_sel = '0;
    logic [2:0]  data_size_sel = '0;
    logic [4:0]  irq_en = '0;
    logic        cmd_load = 1'b0;
    logic [13:0] cmd_load_ptr = '0;
    logic        data_load = 1'b0;
    logic [15:0] data_load_ptr = '0;
    logic        msg_valid = 1'b0;
    logic [8:0]  msg_words = '0;
    logic        msg_ready;
    logic [13:0] cmd_ptr;
    logic [15:0] data_ptr;
    logic        irq_eom, irq_cmd_half, irq_cmd_wrap, irq_data_half, irq_data_wrap;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [31:0] e_cmd;
    logic [31:0] e_data;

    always #2.5 clk = ~clk;

    msg_ring_ptrs u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_size_sel(cmd_size_sel), .data_size_sel(data_size_sel),
        .irq_en(irq_en), .cmd_load(cmd_load), .cmd_load_ptr(cmd_load_ptr),
        .data_load(data_load), .data_load_ptr(data_load_ptr),
        .msg_valid(msg_valid), .msg_words(msg_words), .msg_ready(msg_ready),
        .cmd_ptr(cmd_ptr), .data_ptr(data_ptr), .irq_eom(irq_eom),
        .irq_cmd_half(irq_cmd_half), .irq_cmd_wrap(irq_cmd_wrap),
        .irq_data_half(irq_data_half), .irq_data_wrap(irq_data_wrap)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model(input logic [31:0] p, input int step, input int lg,
                         output logic [31:0] nxt, output bit h, output bit w);
        int size = 1 << lg;
        int off = int'(p) & (size - 1);
        int sum = off + step;
        w   = (sum >= size);
        h   = ((off < size / 2) && (sum >= size / 2)) || (sum >= size + size / 2);
        nxt = (p & ~32'(size - 1)) | 32'(sum & (size - 1));
    endtask

    task automatic do_reset(input logic [1:0] cs, input logic [2:0] ds);
        @(negedge clk);
        rst_n = 1'b0;
        cmd_size_sel = cs;
        data_size_sel = ds;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        e_cmd = '0;
        e_data = '0;
        @(negedge clk);
        chk(cmd_ptr == 0 && data_ptr == 0, "R1 pointers", {cmd_ptr, data_ptr}, 0);
        chk({irq_eom, irq_cmd_half, irq_cmd_wrap, irq_data_half, irq_data_wrap} == 0,
            "R1 irqs", 32'({irq_eom, irq_cmd_half, irq_cmd_wrap, irq_data_half, irq_data_wrap}), 0);
        chk(msg_ready == 1'b1, "R1 ready", 32'(msg_ready), 1);
    endtask

    task automatic run_msg(input int words, input logic [4:0] en, input bit hold_valid);
        logic [31:0] nc, nd;
        bit ch, cw, dh, dw;
        int clg = 8 + 2 * int'(cmd_size_sel);
        int dlg = 9 + int'(data_size_sel);
        model(e_cmd, DESC, clg, nc, ch, cw);
        model(e_data, words, dlg, nd, dh, dw);
        irq_en = en;
        msg_valid = 1'b1;
        msg_words = 9'(words);
        @(posedge clk); @(negedge clk);
        chk(msg_ready == 1'b0, "R2 ready low", 32'(msg_ready), 0);
        if (hold_valid) msg_words = 9'(words ^ 9'h1A5);
        else msg_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(32'(cmd_ptr) == nc, "R2 R5 R7 cmd_ptr", 32'(cmd_ptr), nc);
        chk(irq_cmd_half == (ch & en[1]), "R8 cmd half", 32'(irq_cmd_half), 32'(ch & en[1]));
        chk(irq_cmd_wrap == (cw & en[2]), "R9 cmd wrap", 32'(irq_cmd_wrap), 32'(cw & en[2]));
        chk(32'(data_ptr) == e_data, "R3 data still", 32'(data_ptr), e_data);
        @(posedge clk); @(negedge clk);
        chk(32'(data_ptr) == nd, "R3 R6 R7 data_ptr", 32'(data_ptr), nd);
        chk(irq_data_half == (dh & en[3]), "R8 data half", 32'(irq_data_half), 32'(dh & en[3]));
        chk(irq_data_wrap == (dw & en[4]), "R9 data wrap", 32'(irq_data_wrap), 32'(dw & en[4]));
        chk(!irq_cmd_half && !irq_cmd_wrap, "R10 cmd pulse end", 32'({irq_cmd_half, irq_cmd_wrap}), 0);
        @(posedge clk); @(negedge clk);
        chk(irq_eom == en[0], "R4 eom", 32'(irq_eom), 32'(en[0]));
        chk(msg_ready == 1'b1, "R4 ready back", 32'(msg_ready), 1);
        chk(!irq_data_half && !irq_data_wrap, "R10 data pulse end", 32'({irq_data_half, irq_data_wrap}), 0);
        msg_valid = 1'b0;
        e_cmd = nc;
        e_data = nd;
        if (hold_valid) begin
            @(posedge clk); @(negedge clk);
            chk(32'(cmd_ptr) == e_cmd && msg_ready, "R12 no extra advance", 32'(cmd_ptr), e_cmd);
            chk(irq_eom == 1'b0, "R10 eom pulse end", 32'(irq_eom), 0);
        end
    endtask

    initial begin
        do_reset(2'd0, 3'd0);
        for (int i = 0; i < 200; i++) run_msg((i * 97 + 3) % 512, 5'h1F, (i % 17) == 5);

        do_reset(2'd1, 3'd2);
        for (int i = 0; i < 150; i++) run_msg((i * 131 + 7) % 512, 5'h1F, 1'b0);

        do_reset(2'd0, 3'd0);
        @(negedge clk);
        cmd_load = 1'b1; cmd_load_ptr = 14'h2A05;
        data_load = 1'b1; data_load_ptr = 16'hC064;
        @(posedge clk); @(negedge clk);
        cmd_load = 1'b0; data_load = 1'b0;
        chk(cmd_ptr == 14'h2A05, "R11 cmd preload", 32'(cmd_ptr), 32'h2A05);
        chk(data_ptr == 16'hC064, "R11 data preload", 32'(data_ptr), 32'hC064);
        e_cmd = 32'h2A05; e_data = 32'hC064;
        run_msg(500, 5'h1F, 1'b0);
        for (int i = 0; i < 80; i++) run_msg((i * 61 + 11) % 512, 5'h1F, 1'b0);
        for (int i = 0; i < 20; i++) run_msg(300 + i, 5'h00, 1'b0);

        @(negedge clk);
        cmd_load = 1'b1; cmd_load_ptr = 14'h00FC;
        @(posedge clk); @(negedge clk);
        cmd_load_ptr = 14'h0123;
        irq_en = 5'h1F;
        msg_valid = 1'b1; msg_words = 9'd10;
        @(posedge clk); @(negedge clk);
        msg_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(cmd_ptr == 14'h0123, "R11 load beats advance", 32'(cmd_ptr), 32'h123);
        chk(!irq_cmd_wrap && !irq_cmd_half, "R11 no pulse on load", 32'({irq_cmd_half, irq_cmd_wrap}), 0);
        cmd_load = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        e_cmd = 32'h0123; e_data = 32'(data_ptr);

        do_reset(2'd3, 3'd7);
        @(negedge clk);
        cmd_load = 1'b1; cmd_load_ptr = 14'd16380;
        data_load = 1'b1; data_load_ptr = 16'd65500;
        @(posedge clk); @(negedge clk);
        cmd_load = 1'b0; data_load = 1'b0;
        e_cmd = 32'd16380; e_data = 32'd65500;
        run_msg(100, 5'h1F, 1'b0);
        @(negedge clk);
        data_load = 1'b1; data_load_ptr = 16'd32700;
        @(posedge clk); @(negedge clk);
        data_load = 1'b0;
        e_data = 32'd32700;
        run_msg(100, 5'h1F, 1'b0);
        run_msg(511, 5'h1F, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule